// File: doc/BRIEF.md
# Serial Programming Port With Addressed Word Routing

This block receives 24-bit control words over a three-wire serial port (serial clock, serial data, load strobe) and files each word into one of several holding registers. Bits are shifted in most significant first on rising serial-clock edges while the strobe is high. When the strobe falls, the two bits that arrived last form a destination address. The remaining 22 bits are the payload. Depending on the address, the payload is written to frequency word one, to frequency word two, to the reference word, or only into the A field of whichever frequency word is active at that moment.

A separate select input picks which frequency word is active. The block drives that word's A count, M count, two gain bits and polarity bit straight to the divider and phase-detector logic. The reference word is also presented on its own output. The three serial pins are treated as asynchronous. They pass through a configurable synchroniser into the system clock domain. A frame that holds fewer than 24 bits is dropped. A frame that holds more than 24 bits keeps only the last 24.

Top module: `serial_word_loader`

## Requirements
- R1: After reset the frequency words and the reference word are all zero, so every output reads zero for either select level.
- R2: A data bit is captured on the rising edge of the serial clock, and the first bit sent becomes bit 23 of the frame. The level of the data line during the high phase of the serial clock and at its falling edge has no effect.
- R3: Address bits [1:0] = 00 at the strobe's falling edge writes payload bits [23:2] into frequency word one.
- R4: Address bits [1:0] = 01 writes the payload into frequency word two.
- R5: Address bits [1:0] = 10 replaces only the A field of the frequency word that is active at the falling edge. The M, gain and polarity fields are unchanged, and so is the other word.
- R6: Address bits [1:0] = 11 writes the payload into the reference word and leaves both frequency words unchanged.
- R7: A frame with fewer than 24 captured bits changes no register. In a frame with more than 24 bits, only the last 24 are used.
- R8: With the select input high, the outputs show frequency word one. With it low, they show frequency word two. The outputs follow a change of the select input combinationally.
- R9: While the strobe is high, no holding register changes, whatever is shifted in.
- R10: Payload layout of a frequency word: A is payload bits [3:0] and M is [18:4]. Bit 19 is gain bit 0, bit 20 is gain bit 1 and bit 21 is polarity. The gain output is {bit 20, bit 19}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_ld | input | 1 | Load strobe, high during a frame, asynchronous |
| sel_one | input | 1 | 1 selects frequency word one as active, 0 selects word two |
| act_a | output | 4 | A count of the active word |
| act_m | output | 15 | M count of the active word |
| act_gain | output | 2 | Gain bits of the active word |
| act_pol | output | 1 | Polarity bit of the active word |
| ref_word | output | 22 | Reference word |

## Verification
The bench changes the data line to junk while the serial clock is high. A design that samples on the wrong edge therefore files corrupted words. It sends 23-bit and 27-bit frames. A design that counts wrongly either loads a short frame or keeps the wrong 24 bits of a long one. A-only updates are sent under both select levels. A design that misroutes them writes the inactive word or clobbers M and gain. Outputs are also compared while the strobe is still high after a full frame, which catches a design that loads early.

// File: rtl/ldr_pkg.sv
package ldr_pkg;

   typedef enum logic [1:0] {
      DST_ONE   = 2'b00,
      DST_TWO   = 2'b01,
      DST_AONLY = 2'b10,
      DST_REF   = 2'b11
   } dst_e;

   localparam int NUM_FLAG_BITS = 3;

endpackage

// File: rtl/ldr_sync.sv
module ldr_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stage_q [STAGES];
         for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  stage_q[i] <= '0;
               end else if (i == 0) begin
                  stage_q[i] <= d;
               end else begin
                  stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
               end
            end
         end
         assign q = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/ldr_shifter.sv
module ldr_shifter #(
   parameter int FRAME_W = 24,
   parameter int ADDR_W  = 2,
   localparam int PAY_W  = FRAME_W - ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              dat_s,
   input  logic              ld_s,
   output logic              busy,
   output logic              load,
   output logic [PAY_W-1:0]  payload,
   output logic [ADDR_W-1:0] addr
);

   localparam int CNT_W = $clog2(FRAME_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

   logic               sclk_q, ld_q;
   logic               sclk_rise, ld_rise, ld_fall;
   logic [FRAME_W-1:0] sr_q;
   logic [CNT_W-1:0]   cnt_q;

   assign sclk_rise = sclk_s & ~sclk_q;
   assign ld_rise   = ld_s & ~ld_q;
   assign ld_fall   = ~ld_s & ld_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         ld_q   <= 1'b0;
         sr_q   <= '0;
         cnt_q  <= '0;
      end else begin
         sclk_q <= sclk_s;
         ld_q   <= ld_s;
         if (sclk_rise && ld_s) begin
            sr_q <= {sr_q[FRAME_W-2:0], dat_s};
         end
         if (ld_rise) begin
            cnt_q <= (sclk_rise) ? CNT_W'(1) : '0;
         end else if (sclk_rise && ld_s && (cnt_q != CNT_FULL)) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign busy    = ld_s;
   assign load    = ld_fall && (cnt_q == CNT_FULL);
   assign payload = sr_q[FRAME_W-1:ADDR_W];
   assign addr    = sr_q[ADDR_W-1:0];

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_FULL);  // R7
   AST_SR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_s |=> $stable(sr_q));  // R2

endmodule

// File: rtl/ldr_router.sv
module ldr_router
   import ldr_pkg::*;
#(
   parameter int PAY_W  = 22,
   parameter int ADDR_W = 2,
   parameter int A_W    = 4,
   parameter int M_W    = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              busy,
   input  logic [PAY_W-1:0]  payload,
   input  logic [ADDR_W-1:0] addr,
   input  logic              sel_one,
   output logic [PAY_W-1:0]  one_q,
   output logic [PAY_W-1:0]  two_q,
   output logic [PAY_W-1:0]  ref_q
);

   localparam int M_LO = A_W;
   localparam int M_HI = A_W + M_W - 1;

   dst_e dst;
   logic wr_one, wr_two, wr_a, wr_ref;

   assign dst = dst_e'(addr);

   always_comb begin
      wr_one = 1'b0;
      wr_two = 1'b0;
      wr_a   = 1'b0;
      wr_ref = 1'b0;
      if (load) begin
         unique case (dst)
            DST_ONE:   wr_one = 1'b1;
            DST_TWO:   wr_two = 1'b1;
            DST_AONLY: wr_a   = 1'b1;
            DST_REF:   wr_ref = 1'b1;
            default:   wr_ref = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         one_q <= '0;
         two_q <= '0;
         ref_q <= '0;
      end else begin
         if (wr_one) one_q <= payload;
         if (wr_two) two_q <= payload;
         if (wr_ref) ref_q <= payload;
         if (wr_a) begin
            if (sel_one) one_q[A_W-1:0] <= payload[A_W-1:0];
            else         two_q[A_W-1:0] <= payload[A_W-1:0];
         end
      end
   end

   AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_one, wr_two, wr_a, wr_ref}));  // R3
   AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(one_q) && $stable(two_q) && $stable(ref_q)));  // R9
   AST_REF_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ref |=> ($stable(one_q) && $stable(two_q)));  // R6
   AST_AONLY_KEEPS_M: assert property (@(posedge clk) disable iff (!rst_n)
      wr_a |=> ($stable(one_q[PAY_W-1:M_LO]) && $stable(two_q[PAY_W-1:M_LO])
                && $stable(ref_q)));  // R5
   AST_M_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      wr_two |=> $stable(one_q[M_HI:M_LO]));  // R4

endmodule

// File: rtl/serial_word_loader.sv
module serial_word_loader
   import ldr_pkg::*;
#(
   parameter int FRAME_W     = 24,
   parameter int ADDR_W      = 2,
   parameter int A_W         = 4,
   parameter int M_W         = 15,
   parameter int SYNC_STAGES = 2,
   localparam int PAY_W      = FRAME_W - ADDR_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ser_clk,
   input  logic             ser_dat,
   input  logic             ser_ld,
   input  logic             sel_one,
   output logic [A_W-1:0]   act_a,
   output logic [M_W-1:0]   act_m,
   output logic [1:0]       act_gain,
   output logic             act_pol,
   output logic [PAY_W-1:0] ref_word
);

   localparam int G_LO = A_W + M_W;
   localparam int POL  = G_LO + 2;

   generate
      if (ADDR_W != 2) begin : g_bad_addr
         $error("serial_word_loader: address must be two bits");
      end
      if (PAY_W != A_W + M_W + NUM_FLAG_BITS) begin : g_bad_layout
         $error("serial_word_loader: payload width does not fit A, M and flags");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("serial_word_loader: synchroniser depth out of range");
      end
   endgenerate

   logic [2:0]        pins_s;
   logic              busy, load;
   logic [PAY_W-1:0]  payload;
   logic [ADDR_W-1:0] addr;
   logic [PAY_W-1:0]  one_q, two_q, act_w;

   ldr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ser_ld, ser_dat, ser_clk}),
      .q     (pins_s)
   );

   ldr_shifter #(.FRAME_W(FRAME_W), .ADDR_W(ADDR_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .sclk_s  (pins_s[0]),
      .dat_s   (pins_s[1]),
      .ld_s    (pins_s[2]),
      .busy    (busy),
      .load    (load),
      .payload (payload),
      .addr    (addr)
   );

   ldr_router #(.PAY_W(PAY_W), .ADDR_W(ADDR_W), .A_W(A_W), .M_W(M_W)) u_route (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .busy    (busy),
      .payload (payload),
      .addr    (addr),
      .sel_one (sel_one),
      .one_q   (one_q),
      .two_q   (two_q),
      .ref_q   (ref_q_w)
   );

   logic [PAY_W-1:0] ref_q_w;

   assign act_w    = sel_one ? one_q : two_q;
   assign act_a    = act_w[A_W-1:0];
   assign act_m    = act_w[G_LO-1:A_W];
   assign act_gain = act_w[G_LO+1:G_LO];
   assign act_pol  = act_w[POL];
   assign ref_word = ref_q_w;

   AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !busy);  // R9

endmodule

// File: tb/serial_word_loader_bench.sv
`timescale 1ns/1ps
module serial_word_loader_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ser_clk = 1'b0, ser_dat = 1'b0, ser_ld = 1'b0, sel_one = 1'b1;
   logic [3:0]  act_a;
   logic [14:0] act_m;
   logic [1:0]  act_gain;
   logic        act_pol;
   logic [21:0] ref_word;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   logic [21:0] e_one = '0, e_two = '0, e_ref = '0;

   always #2.5 clk = ~clk;

   serial_word_loader u_serial_word_loader (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
      .ser_ld(ser_ld), .sel_one(sel_one), .act_a(act_a), .act_m(act_m),
      .act_gain(act_gain), .act_pol(act_pol), .ref_word(ref_word)
   );

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cmp(string req, logic [63:0] act, logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Compares both words via the select input, and the reference word
   task automatic check_all(string req);
      logic keep;
      keep = sel_one;
      sel_one = 1'b1;
      #0.5;
      cmp({req, "/R8 one"}, {42'd0, act_pol, act_gain, act_m, act_a}, {42'd0, e_one});
      sel_one = 1'b0;
      #0.5;
      cmp({req, "/R8 two"}, {42'd0, act_pol, act_gain, act_m, act_a}, {42'd0, e_two});
      cmp({req, " ref"}, {42'd0, ref_word}, {42'd0, e_ref});
      sel_one = keep;
      tick(1);
   endtask

   function automatic void model(logic [31:0] fr, int n, logic sel);
      logic [23:0] w;
      logic [21:0] p;
      if (n < 24) return;
      w = fr[23:0];
      p = w[23:2];
      case (w[1:0])
         2'b00: e_one = p;
         2'b01: e_two = p;
         2'b10: if (sel) e_one[3:0] = p[3:0]; else e_two[3:0] = p[3:0];
         default: e_ref = p;
      endcase
   endfunction

   // Sends n bits MSB first; junk on data while the serial clock is high (R2)
   task automatic send(logic [31:0] fr, int n, bit mid_chk);
      ser_ld = 1'b1;
      tick(4);
      for (int i = n - 1; i >= 0; i--) begin
         ser_dat = fr[i];
         tick(4);
         ser_clk = 1'b1;
         tick(4);
         ser_dat = ~fr[i];
         tick(2);
         ser_clk = 1'b0;
         tick(4);
      end
      tick(4);
      if (mid_chk) check_all("R9 strobe high");
      ser_ld = 1'b0;
      model(fr, n, sel_one);
      tick(8);
   endtask

   function automatic logic [31:0] mk(logic pol, logic [1:0] g, logic [14:0] m,
                                      logic [3:0] a, logic [1:0] ad);
      return {8'd0, pol, g, m, a, ad};
   endfunction

   initial begin
      void'($urandom(32'd2024));
      tick(5);
      rst_n = 1'b1;
      tick(2);
      check_all("R1 reset");

      sel_one = 1'b1;
      send(mk(1'b1, 2'b10, 15'h1234, 4'h9, 2'b00), 24, 1'b1);
      check_all("R3 word one");
      cmp("R10 A field", {60'd0, act_a}, 64'h9);
      cmp("R10 M field", {49'd0, act_m}, 64'h1234);
      cmp("R10 gain", {62'd0, act_gain}, 64'h2);
      cmp("R10 polarity", {63'd0, act_pol}, 64'h1);

      send(mk(1'b0, 2'b01, 15'h7ABC, 4'h5, 2'b01), 24, 1'b0);
      check_all("R4 word two");

      send({8'd0, 22'h2A5A5A, 2'b11}, 24, 1'b0);
      check_all("R6 reference");

      sel_one = 1'b1;
      send(mk(1'b0, 2'b11, 15'h7FFF, 4'hE, 2'b10), 24, 1'b0);
      check_all("R5 A-only one");
      sel_one = 1'b0;
      send(mk(1'b1, 2'b00, 15'h0000, 4'h3, 2'b10), 24, 1'b0);
      check_all("R5 A-only two");

      send(mk(1'b1, 2'b11, 15'h0F0F, 4'hF, 2'b00) & 32'h7FFFFF, 23, 1'b0);
      check_all("R7 short frame");
      send({5'd0, 3'b101, 1'b0, 2'b01, 15'h4321, 4'h7, 2'b00}, 27, 1'b0);
      check_all("R7 long frame");

      for (int k = 0; k < 50; k++) begin
         logic [31:0] fr;
         int n;
         fr = $urandom();
         n = 24;
         if ($urandom_range(0, 5) == 0) n = $urandom_range(18, 23);
         else if ($urandom_range(0, 5) == 0) n = $urandom_range(25, 30);
         if (n < 32) fr = fr & ((32'd1 << n) - 1);
         sel_one = $urandom_range(0, 1);
         send(fr, n, (k % 7) == 0);
         check_all("R2 random frame");
      end

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule